// File: doc/BRIEF.md
# Logarithmic Bidirectional Barrel Shifter

This block moves a 32-bit word left or right by any distance from 0 to 31 in one combinational pass. A 2-bit kind code selects one of three shift forms. A left shift brings in zeros at the low end. A logical right shift brings in zeros at the high end. An arithmetic right shift brings in copies of the operand's top bit, so a two's-complement value keeps its sign.

The shift distance is split into its binary digits. There are five mux rows in sequence, with weights 16, 8, 4, 2 and 1. Each row either passes its input through or displaces it by its weight, and one bit of the distance controls each row. A distance of 13 therefore uses only the rows of weight 8, 4 and 1.

The block has no clock and no storage. The result follows the inputs within one combinational settling time. It is meant to sit inside a datapath stage whose registers belong to the surrounding design, so it has no stream handshake of its own.

Top module: `barrel_shifter_log`

## Requirements
- R1: The result equals the operand displaced by the full 5-bit distance. The distance is the sum of the row weights (16, 8, 4, 2, 1) whose controlling distance bit is 1, with bit 4 controlling weight 16 and bit 0 controlling weight 1.
- R2: For a left shift, result bit i equals operand bit i-d for i >= d, and the d lowest result bits are 0.
- R3: For a logical right shift, result bit i equals operand bit i+d for i+d <= 31, and the d highest result bits are 0.
- R4: For an arithmetic right shift, the d highest result bits equal operand bit 31, and the rest match the logical right shift.
- R5: Kind code 2'b00 selects left, 2'b10 selects logical right, and 2'b11 selects arithmetic right.
- R6: Kind code 2'b01 gives exactly the same result as 2'b00 (left shift).
- R7: A distance of 0 returns the operand unchanged for every kind code.
- R8: The result depends only on the present inputs, with no clock cycle of latency. A new input set is reflected before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Operand word |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| kind_i | input | 2 | Shift form: 00 left, 01 left, 10 logical right, 11 arithmetic right |
| result_o | output | 32 | Shifted word |

## Verification
The hardest case to reach from the ports is a negative operand shifted arithmetically by a distance that uses several rows at once. In that case the sign fill must come from the original top bit, not from whatever bit a previous row has already moved into place. The stimulus covers every distance from 0 to 31 under all four kind codes. The operands include the most-negative value, all-ones, the largest positive value and seeded random words, so every combination of rows is exercised with the sign bit both set and clear.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DIST_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    KIND_LEFT     = 2'b00,
    KIND_LEFT_ALT = 2'b01,
    KIND_RIGHT_LG = 2'b10,
    KIND_RIGHT_AR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_kind_decode.sv
module shift_kind_decode
  import shifter_pkg::*;
(
  input  logic [1:0] kind_i,
  output logic       to_left_o,
  output logic       sign_fill_o
);
  always_comb begin
    to_left_o   = 1'b1;
    sign_fill_o = 1'b0;
    case (shift_kind_e'(kind_i))
      KIND_RIGHT_LG: to_left_o = 1'b0;
      KIND_RIGHT_AR: begin
        to_left_o   = 1'b0;
        sign_fill_o = 1'b1;
      end
      default: to_left_o = 1'b1;
    endcase
  end

  // R5: a sign-filling form is never a left form
  always_comb begin
    a_r5_kind_exclusive: assert (!(to_left_o && sign_fill_o))
      else $error("R5 decode conflict");
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int unsigned W    = 32,
  parameter int unsigned DIST = 1
) (
  input  logic [W-1:0] din_i,
  input  logic         en_i,
  input  logic         to_left_i,
  input  logic         fill_i,
  output logic [W-1:0] dout_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic moved;
    if (b >= DIST && b + DIST < W) begin : g_mid
      assign moved = to_left_i ? din_i[b-DIST] : din_i[b+DIST];
    end else if (b >= DIST) begin : g_hi
      assign moved = to_left_i ? din_i[b-DIST] : fill_i;
    end else if (b + DIST < W) begin : g_lo
      assign moved = to_left_i ? 1'b0 : din_i[b+DIST];
    end else begin : g_none
      assign moved = to_left_i ? 1'b0 : fill_i;
    end
    assign dout_o[b] = en_i ? moved : din_i[b];
  end
endmodule

// File: rtl/barrel_shifter_log.sv
module barrel_shifter_log
  import shifter_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  logic [DIST_W-1:0] amount_i,
  input  logic [1:0]        kind_i,
  output logic [WORD_W-1:0] result_o
);
  localparam int unsigned STAGES = DIST_W;

  logic to_left;
  logic sign_fill;
  logic fill_bit;
  logic [WORD_W-1:0] stage_bus [STAGES+1];

  shift_kind_decode u_dec (
    .kind_i      (kind_i),
    .to_left_o   (to_left),
    .sign_fill_o (sign_fill)
  );

  assign fill_bit     = sign_fill & data_i[WORD_W-1];
  assign stage_bus[0] = data_i;

  // R1: largest weight first, one distance bit per row
  for (genvar g = 0; g < STAGES; g++) begin : g_row
    localparam int unsigned BITPOS = STAGES - 1 - g;
    shift_stage #(
      .W    (WORD_W),
      .DIST (1 << BITPOS)
    ) u_row (
      .din_i     (stage_bus[g]),
      .en_i      (amount_i[BITPOS]),
      .to_left_i (to_left),
      .fill_i    (fill_bit),
      .dout_o    (stage_bus[g+1])
    );
  end

  assign result_o = stage_bus[STAGES];

  logic [WORD_W-1:0] low_mask;
  assign low_mask = (WORD_W'(1) << amount_i) - WORD_W'(1);

  always_comb begin
    if (amount_i == '0)
      a_r7_zero_pass: assert (result_o == data_i) else $error("R7 pass-through");
    if (kind_i[1] == 1'b0 && amount_i != '0)
      a_r2_low_zero: assert ((result_o & low_mask) == '0) else $error("R2 low fill");
    if (kind_i == 2'b10 && amount_i != '0)
      a_r3_top_zero: assert (result_o[WORD_W-1] == 1'b0) else $error("R3 high fill");
    if (kind_i == 2'b11)
      a_r4_sign_kept: assert (result_o[WORD_W-1] == data_i[WORD_W-1]) else $error("R4 sign");
  end
endmodule

// File: tb/barrel_shifter_log_tb_top.sv
module barrel_shifter_log_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] data;
  logic [4:0]  amt;
  logic [1:0]  kind;
  logic [31:0] res;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  barrel_shifter_log dut_i (
    .data_i   (data),
    .amount_i (amt),
    .kind_i   (kind),
    .result_o (res)
  );

  function automatic logic [31:0] model(logic [31:0] d, int a, logic [1:0] k);
    logic [31:0] r;
    r = d;
    for (int i = 0; i < a; i++) begin
      if (k[1] == 1'b0)      r = {r[30:0], 1'b0};
      else if (k[0] == 1'b0) r = {1'b0, r[31:1]};
      else                   r = {d[31], r[31:1]};
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s kind=%b amt=%0d data=%h actual=%h expected=%h",
               tag, kind, amt, data, res, exp);
    end
  endtask

  task automatic sweep(logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 32; a++) begin
        @(negedge clk);
        data = d; amt = 5'(a); kind = 2'(k);
        #1;
        if (a == 0)      check("R7", d);
        else if (k == 1) check("R6", model(d, a, 2'b00));
        else if (k == 0) check("R2", model(d, a, 2'b00));
        else if (k == 2) check("R3", model(d, a, 2'b10));
        else             check("R4", model(d, a, 2'b11));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    data = 32'h0; amt = '0; kind = '0;
    @(negedge clk); #1;
    check("R7 reset-state zero", 32'h0);
    // R1 directed: distance 13 uses rows 8,4,1
    @(negedge clk); data = 32'h0000_0001; amt = 5'd13; kind = 2'b00; #1;
    check("R1", 32'h0000_2000);
    // R4 directed example
    @(negedge clk); data = 32'hFFFF_FFEC; amt = 5'd1; kind = 2'b11; #1;
    check("R4", 32'hFFFF_FFF6);
    // R5 directed on one operand, three forms
    @(negedge clk); data = 32'h8000_00F0; amt = 5'd4; kind = 2'b00; #1;
    check("R5", 32'h0000_0F00);
    @(negedge clk); kind = 2'b10; #1;
    check("R5", 32'h0800_000F);
    @(negedge clk); kind = 2'b11; #1;
    check("R5", 32'hF800_000F);
    // R8: changes seen before next edge, no latency
    @(negedge clk); data = 32'h1; amt = 5'd31; kind = 2'b00; #1;
    check("R8", 32'h8000_0000);
    sweep(32'hFFFF_FFFF);
    sweep(32'h8000_0000);
    sweep(32'h7FFF_FFFF);
    sweep(32'h0000_0001);
    sweep(32'h0000_0000);
    for (int n = 0; n < 12; n++) sweep($urandom());
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule